// File: doc/BRIEF.md
# MSI Event Queue Writer

This block takes message-signalled interrupt writes that an upstream decoder has already recognised and files each one as a two-word record into one of several ring-buffer event queues. The queues live in a local entry memory. Each vector has a map entry that names its target queue and gates delivery. A per-vector write-pending latch blocks a vector from filing a second record until software has handled the first and released the latch.

Software works through a single register port. Through it, software programs the vector map, releases pending latches, enables and disables queues, recovers queues from the error state, moves head and tail pointers, and reads or rewrites the stored records. Each queue drives its own interrupt line. The line is high while the queue is enabled and holds unread records.

The register address splits into a 4-bit bank in bits 15:12 and a 12-bit index in bits 11:0. The banks are: 0 vector map, 1 pending release, 2 queue control set, 3 queue control clear, 4 queue state, 5 tail, 6 head, and 7 entry memory. For the map and release banks the index is the vector number. For banks 2 to 6 the index is the queue number. For the entry bank the index is {queue, slot, word}.

Top module: `msiq_writer`

## Requirements
- R1: After reset, every queue reads state 1 (idle), with head and tail both 0 and its interrupt line low. Every map entry reads 0.
- R2: Queue state is one-hot in bits 2:0: 1 is idle, 2 is active, 4 is error. A control-set write with bit 44 set moves an idle queue to active. A control-clear write with bit 44 set moves an active queue to idle.
- R3: A message whose map entry is valid (bit 63), whose pending bit (bit 62) is clear and whose target queue (bits 5:0) is active is stored at the tail slot. The tail then advances by one and the vector's pending bit is set.
- R4: A stored record is laid out as follows. Word 0 has bit 63 = 0, bits 62:59 = type (0xB for a 32-bit address, 0xF for a 64-bit address), bits 58:56 = 0, bits 55:46 = length 1, bits 45:32 = dword address bits 61:48, bits 31:16 = requester ID and bits 15:0 = vector number. Word 1 has bits 63:16 = dword address bits 47:0 and bits 15:0 = message data.
- R5: A message is dropped, with no change to tail or pending bit, when its map entry is invalid, its pending bit is set, its target queue is not active, or its target queue number is not below the queue count.
- R6: A write to the release bank with bit 62 set clears that vector's pending bit. A release write with bit 62 clear has no effect.
- R7: If advancing the tail would make it equal to the head, the record is not stored. Instead the overflow flag (tail register bit 57) is set, the queue enters the error state, the tail stays where it is and the pending bit stays clear.
- R8: A control-clear write with bit 47 set moves an error queue to idle, and with bit 57 set clears the overflow flag. A control-set write with bit 57 set forces the overflow flag on.
- R9: Tail and head wrap from DEPTH-1 to 0.
- R10: A queue's interrupt line is high exactly when that queue is active and its head differs from its tail.
- R11: A message is judged against the pending bit as it was before the cycle. If a pending release and an enqueue of the same vector fall in the same cycle, the set made by the enqueue wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Decoded message present this cycle |
| msg_vec_i | input | $clog2(NUM_VEC) | Vector number |
| msg_is64_i | input | 1 | Message used a 64-bit address |
| msg_dwaddr_i | input | 62 | Dword address of the message write |
| msg_rid_i | input | 16 | Requester ID |
| msg_data_i | input | 16 | Message data |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address, bank and index |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational from address |
| irq_o | output | NUM_Q | Per-queue interrupt lines |

## Verification
Software can release a vector's pending latch in the same cycle that a message for that vector arrives, so the message path and the register path meet on one latch. The bench provokes this by driving a release write and a message on the same clock edge twice. The first time the latch is already set, so the message must be dropped and the latch must end clear. The second time the latch is clear, so the record must land, the tail must move and the latch must end set. Tail and map reads after each collision settle the outcome.

// File: rtl/msiq_pkg.sv
package msiq_pkg;
  localparam int PTR_W  = 7;
  localparam int QSEL_W = 6;

  localparam logic [2:0] QS_IDLE   = 3'b001;
  localparam logic [2:0] QS_ACTIVE = 3'b010;
  localparam logic [2:0] QS_ERROR  = 3'b100;

  typedef enum logic [3:0] {
    BK_MAP   = 4'd0,
    BK_CLR   = 4'd1,
    BK_CSET  = 4'd2,
    BK_CCLR  = 4'd3,
    BK_STATE = 4'd4,
    BK_TAIL  = 4'd5,
    BK_HEAD  = 4'd6,
    BK_ENTRY = 4'd7
  } bank_e;

  localparam int B_VALID = 63;
  localparam int B_PEND  = 62;
  localparam int B_OFLOW = 57;
  localparam int B_E2I   = 47;
  localparam int B_EN    = 44;

  localparam logic [3:0] TY_MSI32 = 4'hB;
  localparam logic [3:0] TY_MSI64 = 4'hF;

  function automatic logic [127:0] pack_entry(input logic        is64,
                                              input logic [61:0] dwa,
                                              input logic [15:0] rid,
                                              input logic [15:0] vec,
                                              input logic [15:0] data);
    logic [6:0] ft;
    ft = {is64 ? TY_MSI64 : TY_MSI32, 3'b000};
    return {1'b0, ft, 10'd1, dwa[61:48], rid, vec, dwa[47:0], data};
  endfunction
endpackage

// File: rtl/msiq_vec_map.sv
module msiq_vec_map import msiq_pkg::*; #(
  parameter int NUM_VEC = 16,
  parameter int IDX_W   = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       map_we_i,
  input  logic                       clr_we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic                       valid_bit_i,
  input  logic                       pend_bit_i,
  input  logic [QSEL_W-1:0]          qsel_i,
  input  logic [$clog2(NUM_VEC)-1:0] look_vec_i,
  input  logic                       set_pend_i,
  output logic                       look_valid_o,
  output logic                       look_pend_o,
  output logic [QSEL_W-1:0]          look_q_o,
  output logic [63:0]                rd_o
);
  localparam int VI_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0]             valid_q;
  logic [NUM_VEC-1:0]             pend_q;
  logic [NUM_VEC-1:0][QSEL_W-1:0] qsel_q;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic hit;
    assign hit = (idx_i == IDX_W'(v));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[v] <= 1'b0;
        pend_q[v]  <= 1'b0;
        qsel_q[v]  <= '0;
      end else begin
        if (map_we_i && hit) begin
          valid_q[v] <= valid_bit_i;
          qsel_q[v]  <= qsel_i;
        end
        if (clr_we_i && hit && pend_bit_i) pend_q[v] <= 1'b0;
        // hardware set dominates a same-cycle release
        if (set_pend_i && look_vec_i == VI_W'(v)) pend_q[v] <= 1'b1;
      end
    end
  end

  assign look_valid_o = valid_q[look_vec_i];
  assign look_pend_o  = pend_q[look_vec_i];
  assign look_q_o     = qsel_q[look_vec_i];

  always_comb begin
    rd_o = '0;
    if (int'(idx_i) < NUM_VEC) begin
      rd_o[B_VALID]      = valid_q[idx_i[VI_W-1:0]];
      rd_o[B_PEND]       = pend_q[idx_i[VI_W-1:0]];
      rd_o[QSEL_W-1:0]   = qsel_q[idx_i[VI_W-1:0]];
    end
  end
endmodule

// File: rtl/msiq_queue.sv
module msiq_queue import msiq_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cset_we_i,
  input  logic             cclr_we_i,
  input  logic             tail_we_i,
  input  logic             head_we_i,
  input  logic             en_bit_i,
  input  logic             oflow_bit_i,
  input  logic             e2i_bit_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             enq_i,
  output logic [2:0]       state_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [PTR_W-1:0] head_o,
  output logic             oflow_o,
  output logic             store_o,
  output logic             irq_o
);
  logic [2:0]       state_q;
  logic [PTR_W-1:0] tail_q, head_q, tail_nxt;
  logic             oflow_q, active, full;

  assign active   = (state_q == QS_ACTIVE);
  assign tail_nxt = (tail_q == PTR_W'(DEPTH-1)) ? '0 : tail_q + PTR_W'(1);
  assign full     = (tail_nxt == head_q);
  assign store_o  = enq_i && active && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= QS_IDLE;
      tail_q  <= '0;
      head_q  <= '0;
      oflow_q <= 1'b0;
    end else begin
      if (enq_i && active) begin
        if (full) begin
          oflow_q <= 1'b1;
          state_q <= QS_ERROR;
        end else begin
          tail_q <= tail_nxt;
        end
      end
      // software writes take priority over the hardware update
      if (cset_we_i) begin
        if (en_bit_i && state_q == QS_IDLE) state_q <= QS_ACTIVE;
        if (oflow_bit_i) oflow_q <= 1'b1;
      end
      if (cclr_we_i) begin
        if (en_bit_i && state_q == QS_ACTIVE) state_q <= QS_IDLE;
        if (e2i_bit_i && state_q == QS_ERROR) state_q <= QS_IDLE;
        if (oflow_bit_i) oflow_q <= 1'b0;
      end
      if (tail_we_i) tail_q <= ptr_i;
      if (head_we_i) head_q <= ptr_i;
    end
  end

  assign state_o = state_q;
  assign tail_o  = tail_q;
  assign head_o  = head_q;
  assign oflow_o = oflow_q;
  assign irq_o   = active && (head_q != tail_q);
endmodule

// File: rtl/msiq_entry_mem.sv
module msiq_entry_mem #(
  parameter int MI_W = 6
) (
  input  logic            clk_i,
  input  logic            hw_we_i,
  input  logic [MI_W-1:0] hw_idx_i,
  input  logic [127:0]    hw_entry_i,
  input  logic            sw_we_i,
  input  logic [MI_W-1:0] acc_idx_i,
  input  logic            acc_word_i,
  input  logic [63:0]     sw_data_i,
  output logic [63:0]     rd_o
);
  localparam int ENTRIES = 1 << MI_W;

  logic [63:0] w0_mem [ENTRIES];
  logic [63:0] w1_mem [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (sw_we_i) begin
      if (acc_word_i) w1_mem[acc_idx_i] <= sw_data_i;
      else            w0_mem[acc_idx_i] <= sw_data_i;
    end
    if (hw_we_i) begin
      w0_mem[hw_idx_i] <= hw_entry_i[127:64];
      w1_mem[hw_idx_i] <= hw_entry_i[63:0];
    end
  end

  assign rd_o = acc_word_i ? w1_mem[acc_idx_i] : w0_mem[acc_idx_i];
endmodule

// File: rtl/msiq_writer.sv
module msiq_writer import msiq_pkg::*; #(
  parameter int NUM_VEC = 16,
  parameter int NUM_Q   = 4,
  parameter int DEPTH   = 16,
  parameter int ADDR_W  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       msg_valid_i,
  input  logic [$clog2(NUM_VEC)-1:0] msg_vec_i,
  input  logic                       msg_is64_i,
  input  logic [61:0]                msg_dwaddr_i,
  input  logic [15:0]                msg_rid_i,
  input  logic [15:0]                msg_data_i,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [63:0]                reg_wdata_i,
  output logic [63:0]                reg_rdata_o,
  output logic [NUM_Q-1:0]           irq_o
);
  localparam int QI_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int MI_W   = QI_W + SLOT_W;
  localparam int IDX_W  = ADDR_W - 4;

  bank_e            bank;
  logic [IDX_W-1:0] idx;
  assign bank = bank_e'(reg_addr_i[ADDR_W-1 -: 4]);
  assign idx  = reg_addr_i[IDX_W-1:0];

  logic              look_valid, look_pend, enq_req, set_pend;
  logic [QSEL_W-1:0] look_q;
  logic [QI_W-1:0]   tq;
  logic [63:0]       map_rd, mem_rd;

  msiq_vec_map #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_map (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .map_we_i     (reg_we_i && bank == BK_MAP),
    .clr_we_i     (reg_we_i && bank == BK_CLR),
    .idx_i        (idx),
    .valid_bit_i  (reg_wdata_i[B_VALID]),
    .pend_bit_i   (reg_wdata_i[B_PEND]),
    .qsel_i       (reg_wdata_i[QSEL_W-1:0]),
    .look_vec_i   (msg_vec_i),
    .set_pend_i   (set_pend),
    .look_valid_o (look_valid),
    .look_pend_o  (look_pend),
    .look_q_o     (look_q),
    .rd_o         (map_rd)
  );

  assign enq_req = msg_valid_i && look_valid && !look_pend && (int'(look_q) < NUM_Q);
  assign tq      = look_q[QI_W-1:0];

  logic [NUM_Q-1:0][2:0]       q_state;
  logic [NUM_Q-1:0][PTR_W-1:0] q_tail, q_head;
  logic [NUM_Q-1:0]            q_oflow, q_store, cset_we, cclr_we, tail_we, head_we;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic sel;
    assign sel        = reg_we_i && (idx == IDX_W'(q));
    assign cset_we[q] = sel && bank == BK_CSET;
    assign cclr_we[q] = sel && bank == BK_CCLR;
    assign tail_we[q] = sel && bank == BK_TAIL;
    assign head_we[q] = sel && bank == BK_HEAD;

    msiq_queue #(.DEPTH(DEPTH)) u_queue (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cset_we_i   (cset_we[q]),
      .cclr_we_i   (cclr_we[q]),
      .tail_we_i   (tail_we[q]),
      .head_we_i   (head_we[q]),
      .en_bit_i    (reg_wdata_i[B_EN]),
      .oflow_bit_i (reg_wdata_i[B_OFLOW]),
      .e2i_bit_i   (reg_wdata_i[B_E2I]),
      .ptr_i       (reg_wdata_i[PTR_W-1:0]),
      .enq_i       (enq_req && tq == QI_W'(q)),
      .state_o     (q_state[q]),
      .tail_o      (q_tail[q]),
      .head_o      (q_head[q]),
      .oflow_o     (q_oflow[q]),
      .store_o     (q_store[q]),
      .irq_o       (irq_o[q])
    );
  end

  assign set_pend = |q_store;

  msiq_entry_mem #(.MI_W(MI_W)) u_mem (
    .clk_i      (clk_i),
    .hw_we_i    (set_pend),
    .hw_idx_i   ({tq, q_tail[tq][SLOT_W-1:0]}),
    .hw_entry_i (pack_entry(msg_is64_i, msg_dwaddr_i, msg_rid_i,
                            16'(msg_vec_i), msg_data_i)),
    .sw_we_i    (reg_we_i && bank == BK_ENTRY),
    .acc_idx_i  (idx[MI_W:1]),
    .acc_word_i (idx[0]),
    .sw_data_i  (reg_wdata_i),
    .rd_o       (mem_rd)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (bank)
      BK_MAP:   reg_rdata_o = map_rd;
      BK_ENTRY: reg_rdata_o = mem_rd;
      BK_STATE: if (int'(idx) < NUM_Q) reg_rdata_o[2:0] = q_state[idx[QI_W-1:0]];
      BK_HEAD:  if (int'(idx) < NUM_Q) reg_rdata_o[PTR_W-1:0] = q_head[idx[QI_W-1:0]];
      BK_TAIL:  if (int'(idx) < NUM_Q) begin
        reg_rdata_o[PTR_W-1:0] = q_tail[idx[QI_W-1:0]];
        reg_rdata_o[B_OFLOW]   = q_oflow[idx[QI_W-1:0]];
      end
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/msiq_writer_chk.sv
module msiq_writer_chk import msiq_pkg::*; #(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_Q-1:0][2:0]       q_state,
  input logic [NUM_Q-1:0][PTR_W-1:0] q_tail,
  input logic [NUM_Q-1:0]            q_oflow,
  input logic [NUM_Q-1:0]            tail_we,
  input logic [NUM_Q-1:0]            cclr_we,
  input logic [NUM_Q-1:0]            irq_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_a
    a_r2_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(q_state[q]) == 1);

    a_r10_irq_only_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[q] |-> q_state[q] == QS_ACTIVE);

    a_r3_tail_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !$past(tail_we[q]) && q_tail[q] != $past(q_tail[q])) |->
      q_tail[q] == (($past(q_tail[q]) == PTR_W'(DEPTH-1)) ? PTR_W'(0)
                                                           : $past(q_tail[q]) + PTR_W'(1)));

    a_r7_error_has_oflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && q_state[q] == QS_ERROR && $past(q_state[q]) != QS_ERROR
       && !$past(cclr_we[q])) |-> q_oflow[q]);

    a_r7_error_freezes_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && q_state[q] == QS_ERROR && $past(q_state[q]) == QS_ERROR
       && !$past(tail_we[q])) |-> $stable(q_tail[q]));
  end
endmodule

bind msiq_writer msiq_writer_chk #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .q_state (q_state),
  .q_tail  (q_tail),
  .q_oflow (q_oflow),
  .tail_we (tail_we),
  .cclr_we (cclr_we),
  .irq_o   (irq_o)
);

// File: tb/test_msiq_writer.sv
module test_msiq_writer;
  localparam logic [63:0] VL = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PD = 64'h4000_0000_0000_0000;
  localparam logic [63:0] OF = 64'h0200_0000_0000_0000;
  localparam logic [63:0] E2 = 64'h0000_8000_0000_0000;
  localparam logic [63:0] EN = 64'h0000_1000_0000_0000;
  // message encoding: [3:0] vec, [4] is64, [31:16] rid, [47:32] data
  localparam logic [63:0] MA = 64'h0000_5A5A_0100_0003;
  localparam logic [63:0] MB = 64'h0000_1111_0200_0013;

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read check, 2 message, 3 entry check
    logic [15:0] addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 36;
  localparam step_t TBL [NSTEP] = '{
    '{2'd1, 16'h4000, 64'h0, 64'h1, 4'd1},        // R1 idle
    '{2'd1, 16'h5000, 64'h0, 64'h0, 4'd1},        // R1 tail 0
    '{2'd1, 16'h0003, 64'h0, 64'h0, 4'd1},        // R1 map 0
    '{2'd0, 16'h0003, VL | 64'h1, 64'h0, 4'd3},
    '{2'd0, 16'h2001, EN, 64'h0, 4'd2},
    '{2'd1, 16'h4001, 64'h0, 64'h2, 4'd2},        // R2 active
    '{2'd2, 16'h0000, MA, 64'h0, 4'd3},
    '{2'd1, 16'h5001, 64'h0, 64'h1, 4'd3},        // R3 tail advanced
    '{2'd1, 16'h0003, 64'h0, VL | PD | 64'h1, 4'd3}, // R3 pending set
    '{2'd3, 16'h7020, MA, 64'h0, 4'd4},           // R4 word0
    '{2'd3, 16'h7021, MA, 64'h0, 4'd4},           // R4 word1
    '{2'd2, 16'h0000, MA, 64'h0, 4'd5},
    '{2'd1, 16'h5001, 64'h0, 64'h1, 4'd5},        // R5 pending blocks
    '{2'd0, 16'h1003, 64'h0, 64'h0, 4'd6},
    '{2'd1, 16'h0003, 64'h0, VL | PD | 64'h1, 4'd6}, // R6 no-bit release ignored
    '{2'd0, 16'h1003, PD, 64'h0, 4'd6},
    '{2'd1, 16'h0003, 64'h0, VL | 64'h1, 4'd6},   // R6 released
    '{2'd2, 16'h0000, MB, 64'h0, 4'd3},
    '{2'd1, 16'h5001, 64'h0, 64'h2, 4'd3},        // R3
    '{2'd3, 16'h7022, MB, 64'h0, 4'd4},           // R4 64-bit word0
    '{2'd3, 16'h7023, MB, 64'h0, 4'd4},           // R4 64-bit word1
    '{2'd0, 16'h0005, VL | 64'h2, 64'h0, 4'd5},
    '{2'd2, 16'h0000, 64'h5, 64'h0, 4'd5},
    '{2'd1, 16'h5002, 64'h0, 64'h0, 4'd5},        // R5 queue idle
    '{2'd1, 16'h0005, 64'h0, VL | 64'h2, 4'd5},
    '{2'd0, 16'h0006, VL | 64'h9, 64'h0, 4'd5},
    '{2'd2, 16'h0000, 64'h6, 64'h0, 4'd5},
    '{2'd1, 16'h0006, 64'h0, VL | 64'h9, 4'd5},   // R5 queue out of range
    '{2'd2, 16'h0000, 64'h7, 64'h0, 4'd5},
    '{2'd1, 16'h0007, 64'h0, 64'h0, 4'd5},        // R5 invalid map
    '{2'd0, 16'h3001, EN, 64'h0, 4'd2},
    '{2'd1, 16'h4001, 64'h0, 64'h1, 4'd2},        // R2 disabled
    '{2'd0, 16'h1003, PD, 64'h0, 4'd6},
    '{2'd2, 16'h0000, MA, 64'h0, 4'd5},
    '{2'd1, 16'h5001, 64'h0, 64'h2, 4'd5},        // R5 disabled queue
    '{2'd1, 16'h0003, 64'h0, VL | 64'h1, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0, msg_is64 = 1'b0;
  logic [3:0]  msg_vec = '0;
  logic [61:0] msg_dwaddr = '0;
  logic [15:0] msg_rid = '0, msg_data = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  irq;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  msiq_writer i_msiq_writer (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_vec_i(msg_vec),
    .msg_is64_i(msg_is64), .msg_dwaddr_i(msg_dwaddr), .msg_rid_i(msg_rid),
    .msg_data_i(msg_data), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  function automatic logic [61:0] dwa_of(input logic is64);
    return is64 ? {14'h2ABC, 48'h0000_1234_5678} : {14'h0, 48'h0000_3FB8_0400};
  endfunction

  function automatic logic [63:0] exp_entry(input logic [63:0] m, input logic word);
    logic [61:0] a;
    a = dwa_of(m[4]);
    if (word) return {a[47:0], m[47:32]};
    return {1'b0, (m[4] ? 4'hF : 4'hB), 3'b000, 10'd1, a[61:48], m[31:16], 12'h0, m[3:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic put_msg(input logic [63:0] m);
    msg_vec = m[3:0]; msg_is64 = m[4]; msg_rid = m[31:16];
    msg_data = m[47:32]; msg_dwaddr = dwa_of(m[4]); msg_valid = 1'b1;
  endtask

  task automatic send(input logic [63:0] m);
    @(negedge clk); put_msg(m);
    @(negedge clk); msg_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic collide(input logic [63:0] m);
    @(negedge clk); reg_we = 1'b1; reg_addr = 16'h1000 | 16'(m[3:0]); reg_wdata = PD;
    put_msg(m);
    @(negedge clk); reg_we = 1'b0; msg_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 irq", 64'(irq), 64'h0);

    for (int i = 0; i < NSTEP; i++) begin
      case (TBL[i].op)
        2'd0: wr(TBL[i].addr, TBL[i].data);
        2'd1: rd(TBL[i].addr, TBL[i].exp, $sformatf("R%0d step %0d", TBL[i].req, i));
        2'd2: send(TBL[i].data);
        default: rd(TBL[i].addr, exp_entry(TBL[i].data, TBL[i].addr[0]),
                    $sformatf("R%0d step %0d", TBL[i].req, i));
      endcase
    end

    // R10: disabled queue with unread entries stays quiet, enabled one raises
    @(negedge clk); #1; check("R10 disabled q1", 64'(irq[1]), 64'h0);
    wr(16'h2001, EN);
    #1; check("R10 enabled q1", 64'(irq[1]), 64'h1);
    wr(16'h6001, 64'h2);
    #1; check("R10 head caught up", 64'(irq[1]), 64'h0);

    // R7: fill queue 0 until the ring is full
    wr(16'h0000, VL);
    wr(16'h2000, EN);
    for (int k = 0; k < 15; k++) begin
      send(64'h0);
      wr(16'h1000, PD);
    end
    rd(16'h5000, 64'd15, "R7 ring filled");
    send(64'h0);
    rd(16'h5000, OF | 64'd15, "R7 overflow flag, tail held");
    rd(16'h4000, 64'h4, "R7 error state");
    rd(16'h0000, VL, "R7 pending not set");

    // R8: recovery
    wr(16'h3000, E2);
    rd(16'h4000, 64'h1, "R8 error to idle");
    rd(16'h5000, OF | 64'd15, "R8 overflow kept");
    wr(16'h3000, OF);
    rd(16'h5000, 64'd15, "R8 overflow cleared");
    wr(16'h2000, OF);
    rd(16'h5000, OF | 64'd15, "R8 overflow forced");
    wr(16'h3000, OF);

    // R9: tail wraps from DEPTH-1 to 0
    wr(16'h6000, 64'd5);
    wr(16'h2000, EN);
    send(64'h0);
    rd(16'h5000, 64'd0, "R9 tail wrapped");
    rd(16'h701E, exp_entry(64'h0, 1'b0), "R9 last slot written");
    @(negedge clk); #1; check("R10 q0 pending entries", 64'(irq[0]), 64'h1);

    // R11: release and message on the same edge
    collide(64'h0);
    rd(16'h5000, 64'd0, "R11 message dropped on old pending");
    rd(16'h0000, VL, "R11 pending released");
    collide(64'h0);
    rd(16'h5000, 64'd1, "R11 message stored");
    rd(16'h0000, VL | PD, "R11 set wins");

    wr(16'h6000, 64'd1);
    #1; check("R10 q0 drained", 64'(irq[0]), 64'h0);

    // R1: mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(16'h4000, 64'h1, "R1 idle after reset");
    rd(16'h5000, 64'h0, "R1 tail after reset");
    rd(16'h6000, 64'h0, "R1 head after reset");
    rd(16'h0000, 64'h0, "R1 map after reset");
    check("R1 irq after reset", 64'(irq), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule